// File: doc/BRIEF.md
# Byte-Maskable Dual-Read Register File

This block is a small general-purpose register file: eight registers of sixteen bits, one write port and two read ports. A write names a destination register, supplies sixteen bits of data and gives a two-bit lane mask. The mask picks which bytes of the destination take the new data: the low byte, the high byte, both, or neither. The write takes effect on the rising clock edge. Destination, data and mask are all sampled at that one edge, so a caller that changes all three in the same cycle sees the new data land in the newly named register at the next edge, with no second edge needed.

The two read ports are combinational. Each takes a register index and drives that register's contents straight away, with no clock edge in between. A read of the register that is being written shows the stored value until the edge and the masked result right after it. A synchronous active-high reset clears every register to zero.

The write port has no valid/ready handshake. Every edge commits the write it sees, and there is no back-pressure. A mask of zero is how a caller asks for no write in a cycle. The read ports have no handshake either: they are plain index-in, data-out paths.

Top module: `bytemask_regfile`

## Requirements
- R1: The file holds eight independent 16-bit registers, each chosen by a 3-bit index (0 to 7) on the write port and on both read ports.
- R2: Each read port is combinational: its data output follows a change of its index in the same cycle, with no clock edge.
- R3: Lane mask 3 (bit 0 selects bits 7:0, bit 1 selects bits 15:8) writes all 16 bits of the write data into the destination at the rising edge.
- R4: Lane mask 0 leaves the destination register unchanged.
- R5: Lane mask 1 writes bits 7:0 from the write data and keeps bits 15:8 of the destination.
- R6: Lane mask 2 writes bits 15:8 from the write data and keeps bits 7:0 of the destination.
- R7: A write changes only the register named by the destination index. The other seven keep their values.
- R8: Destination index, write data and lane mask that all change in the same cycle take effect together on the next rising edge.
- R9: A synchronous active-high reset clears all eight registers to zero at the edge. Reset wins over a write presented at that same edge.
- R10: A read port pointed at the register being written shows the old value before the edge and the new masked value right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all registers |
| wr_idx | input | 3 | Destination register index |
| wr_data | input | 16 | Write data |
| wr_lanes | input | 2 | Lane mask: bit 0 low byte, bit 1 high byte |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_data | output | 16 | Read port 0 data, combinational |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_data | output | 16 | Read port 1 data, combinational |

## Verification
A read result is due in the same cycle as its index, so the bench drives the read indices and the write fields at the falling edge. It samples both read ports 1 ns later against the reference model as it stood before the write, which also checks that a write is not yet visible. A write is due one edge later. The driver pushes the post-edge expectation for both ports into a scoreboard, and a monitor pops it and compares 1 ns after the rising edge. Reset is checked the same way, one edge after it is raised. The bench then sweeps all eight indices across both ports within one low phase of the clock.

// File: rtl/rf_pkg.sv
package rf_pkg;
  parameter int unsigned NUM_REGS = 8;
  parameter int unsigned REG_W    = 16;
  parameter int unsigned LANE_W   = 8;
  localparam int unsigned IDX_W   = $clog2(NUM_REGS);
  localparam int unsigned LANES   = REG_W / LANE_W;

  typedef logic [IDX_W-1:0]                 idx_t;
  typedef logic [REG_W-1:0]                 word_t;
  typedef logic [LANES-1:0]                 lanes_t;
  typedef logic [NUM_REGS-1:0][REG_W-1:0]   bank_t;
endpackage

// File: rtl/rf_index_decode.sv
module rf_index_decode
  import rf_pkg::*;
(
  input  idx_t                idx_i,
  output logic [NUM_REGS-1:0] sel_o
);
  always_comb begin
    sel_o = '0;
    sel_o[idx_i] = 1'b1;
  end
endmodule

// File: rtl/rf_lane_reg.sv
module rf_lane_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)       q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= 1'b1;

  AST_LANE_LOADS: assert property (@(posedge clk) disable iff (!past_ok)
    (!$past(rst) && $past(ld_i)) |-> (q_o == $past(d_i))); // R3
  AST_LANE_HOLDS: assert property (@(posedge clk) disable iff (!past_ok)
    (!$past(rst) && !$past(ld_i)) |-> $stable(q_o)); // R4
  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!past_ok)
    $past(rst) |-> (q_o == '0)); // R9
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux
  import rf_pkg::*;
(
  input  bank_t bank_i,
  input  idx_t  idx_i,
  output word_t data_o
);
  always_comb data_o = bank_i[idx_i];
endmodule

// File: rtl/bytemask_regfile.sv
module bytemask_regfile
  import rf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [REG_W-1:0]     wr_data,
  input  logic [LANES-1:0]     wr_lanes,
  input  logic [IDX_W-1:0]     rd0_idx,
  output logic [REG_W-1:0]     rd0_data,
  input  logic [IDX_W-1:0]     rd1_idx,
  output logic [REG_W-1:0]     rd1_data
);
  logic [NUM_REGS-1:0] reg_sel;
  bank_t               bank;

  rf_index_decode u_dec (
    .idx_i (wr_idx),
    .sel_o (reg_sel)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic lane_ld;
      assign lane_ld = reg_sel[r] & wr_lanes[l];
      rf_lane_reg #(.W(LANE_W)) u_lane (
        .clk  (clk),
        .rst  (rst),
        .ld_i (lane_ld),
        .d_i  (wr_data[l*LANE_W +: LANE_W]),
        .q_o  (bank[r][l*LANE_W +: LANE_W])
      );
    end
  end

  rf_read_mux u_rd0 (.bank_i(bank), .idx_i(rd0_idx), .data_o(rd0_data));
  rf_read_mux u_rd1 (.bank_i(bank), .idx_i(rd1_idx), .data_o(rd1_data));

  logic past_ok;
  always_ff @(posedge clk) past_ok <= 1'b1;

  AST_OTHER_REG_KEPT: assert property (@(posedge clk) disable iff (!past_ok)
    (!$past(rst) && $stable(rd0_idx) && (rd0_idx != $past(wr_idx)))
      |-> $stable(rd0_data)); // R7
  AST_MASK_ZERO_KEPT: assert property (@(posedge clk) disable iff (!past_ok)
    (!$past(rst) && $stable(rd1_idx) && ($past(wr_lanes) == '0))
      |-> $stable(rd1_data)); // R4
  AST_FULL_WRITE_SEEN: assert property (@(posedge clk) disable iff (!past_ok)
    (!$past(rst) && $stable(rd0_idx) && (rd0_idx == $past(wr_idx))
      && ($past(wr_lanes) == '1)) |-> (rd0_data == $past(wr_data))); // R8
  AST_RESET_READS_ZERO: assert property (@(posedge clk) disable iff (!past_ok)
    $past(rst) |-> (rd0_data == '0 && rd1_data == '0)); // R9
endmodule

// File: tb/bytemask_regfile_tb.sv
`timescale 1ns/100ps
module bytemask_regfile_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic [2:0]  wr_idx = '0, rd0_idx = '0, rd1_idx = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_lanes = '0;
  logic [15:0] rd0_data, rd1_data;

  int errors = 0;
  int checks = 0;
  logic [15:0] model [8];

  logic [15:0] q_e0[$];
  logic [15:0] q_e1[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  bytemask_regfile u_dut (
    .clk(clk), .rst(rst), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_lanes(wr_lanes), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_data(rd1_data)
  );

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: present one cycle of stimulus, check the pre-edge reads,
  // then queue what both ports must show after the edge.
  task automatic drive(logic r, logic [2:0] wi, logic [15:0] wd, logic [1:0] wl,
                       logic [2:0] r0, logic [2:0] r1, string tag);
    logic [15:0] nv;
    @(negedge clk);
    rst = r; wr_idx = wi; wr_data = wd; wr_lanes = wl;
    rd0_idx = r0; rd1_idx = r1;
    #1;
    check(tag, "pre-edge port0", rd0_data, model[r0]); // R2, R10
    check(tag, "pre-edge port1", rd1_data, model[r1]);
    if (r) begin
      for (int i = 0; i < 8; i++) model[i] = '0;
    end else begin
      nv = model[wi];
      if (wl[0]) nv[7:0]  = wd[7:0];
      if (wl[1]) nv[15:8] = wd[15:8];
      model[wi] = nv;
    end
    q_e0.push_back(model[r0]);
    q_e1.push_back(model[r1]);
    q_tag.push_back(tag);
  endtask

  // Monitor: compare 1 ns after each rising edge.
  always @(posedge clk) begin
    #1;
    if (q_tag.size() > 0) begin
      string t;
      logic [15:0] e0, e1;
      t = q_tag.pop_front(); e0 = q_e0.pop_front(); e1 = q_e1.pop_front();
      check(t, "post-edge port0", rd0_data, e0);
      check(t, "post-edge port1", rd1_data, e1);
    end
  end

  task automatic sweep(string tag);
    @(negedge clk);
    rst = 1'b0; wr_lanes = 2'b00;
    for (int i = 0; i < 8; i++) begin
      rd0_idx = 3'(i); rd1_idx = 3'(7 - i);
      #0.2;
      check(tag, "sweep port0", rd0_data, model[i]);
      check(tag, "sweep port1", rd1_data, model[7 - i]);
    end
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    sweep("R9_reset");
    // R1: distinct value in every register
    for (int i = 0; i < 8; i++)
      drive(0, 3'(i), 16'h1111 * 16'(i + 1), 2'b11, 3'(i), 3'(7 - i), "R1");
    sweep("R1");
    drive(0, 3'd2, 16'hABCD, 2'b11, 3'd2, 3'd3, "R3");
    drive(0, 3'd2, 16'h5555, 2'b00, 3'd2, 3'd1, "R4");
    drive(0, 3'd2, 16'h9876, 2'b01, 3'd2, 3'd0, "R5");
    drive(0, 3'd2, 16'h1234, 2'b10, 3'd2, 3'd4, "R6");
    drive(0, 3'd5, 16'hFFFF, 2'b11, 3'd4, 3'd6, "R7");
    sweep("R7");
    // R8: index, data and mask all change together across successive cycles
    drive(0, 3'd0, 16'hC0DE, 2'b11, 3'd0, 3'd1, "R8");
    drive(0, 3'd1, 16'hBEEF, 2'b10, 3'd0, 3'd1, "R8");
    drive(0, 3'd7, 16'h0F0F, 2'b01, 3'd7, 3'd1, "R8");
    // R10: both ports on the register being written
    drive(0, 3'd3, 16'h4242, 2'b11, 3'd3, 3'd3, "R10");
    // R2: index moves while no write happens
    drive(0, 3'd3, 16'h0000, 2'b00, 3'd6, 3'd0, "R2");
    // R9: reset wins over a concurrent write
    drive(1, 3'd4, 16'h7777, 2'b11, 3'd4, 3'd5, "R9");
    sweep("R9");
    for (int n = 0; n < 1000; n++)
      drive(0, 3'($urandom), 16'($urandom), 2'($urandom),
            3'($urandom), 3'($urandom), "R7_random");
    sweep("R1_final");
    @(negedge clk); @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule